// File: doc/BRIEF.md
# Bounded-Density Weight Block Packer

This block turns a stream of 8-element weight blocks, each element a signed 8-bit integer taken along the channel dimension, into fixed-length compressed records. With every block the producer supplies a density limit, `in_bound`, from 1 to 8. The limit may change from one block to the next. The packer removes the zero elements and gathers the non-zero ones into the lowest value slots, keeping their original position order. It fills any remaining slots up to the limit with zeros. It also attaches a presence mask with one bit per element position.

A block with more non-zero elements than the limit allows is flagged on `out_over`. The value slots of such a record carry no defined meaning. The record size is therefore 8·bound + 8 bits: `bound` value bytes plus the mask byte. The packer drives slots at and above the limit to zero, so the full record fits one wide output beat.

Both sides use valid/ready handshakes. One register stage holds the record, which gives one cycle of latency. The packer accepts a new block in every cycle in which the consumer takes the previous record.

Top module: `dbb_pack_top`

## Requirements
- R1: The cycle after a cycle with `rst` high, `out_valid` is low. After reset, `in_ready` is high.
- R2: Element i of a block occupies `in_data[8*i+7:8*i]`. Bit i of `out_mask` is 1 exactly when element i is non-zero.
- R3: When `out_over` is low, value slot k (`out_vals[8*k+7:8*k]`) holds the k-th non-zero element, counted in ascending position order, for every k below the non-zero count.
- R4: Slots from the non-zero count up to `bound`-1 are zero padding. Slots at or above `bound` are driven to zero. Padding sets no mask bit.
- R5: `out_over` is 1 exactly when the block's non-zero count exceeds its `bound`.
- R6: `out_bound` carries the limit that was sampled together with the block in the same transfer.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all output fields hold their values.
- R8: A block accepted in cycle t is presented with `out_valid` high in cycle t+1. A new block is accepted in any cycle in which the held record is taken.
- R9: Consecutive blocks with different limits are each packed against their own limit, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Packer can take a block |
| in_data | input | 64 | Eight signed bytes, element 0 in the low byte |
| in_bound | input | 4 | Non-zero limit for this block, 1..8 |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Consumer takes the record |
| out_vals | output | 64 | Compacted value slots, slot 0 in the low byte |
| out_mask | output | 8 | Presence mask, bit i for element i |
| out_bound | output | 4 | Limit the record was packed against |
| out_over | output | 1 | Block held more non-zeros than the limit |

## Verification
The assertions take two things for granted about the producer. First, `in_bound` is within 1..8. Second, it is sampled only together with its block, so a limit is never applied to part of a block. The packer registers both values at the transfer, so any change the producer makes between transfers cannot affect a record already held. The stimulus uses only limits from 1 to 8. It keeps the data and the limit unchanged while a block waits under backpressure, and it changes them only at the transfer edges.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
  localparam int BLK_N  = 8;
  localparam int ELEM_W = 8;
  localparam int CNT_W  = $clog2(BLK_N + 1);
  localparam int DATA_W = BLK_N * ELEM_W;

  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/dbb_nz_scan.sv
module dbb_nz_scan #(
  parameter int BLK_N  = 8,
  parameter int ELEM_W = 8,
  parameter int CNT_W  = $clog2(BLK_N + 1)
) (
  input  logic [BLK_N*ELEM_W-1:0] data,
  output logic [BLK_N-1:0]        mask,
  output logic [BLK_N*CNT_W-1:0]  rank,
  output logic [CNT_W-1:0]        count
);
  logic [CNT_W-1:0] run [BLK_N+1];

  assign run[0] = '0;

  genvar gi;
  generate
    for (gi = 0; gi < BLK_N; gi++) begin : g_elem
      assign mask[gi] = |data[gi*ELEM_W +: ELEM_W];
      assign rank[gi*CNT_W +: CNT_W] = run[gi];
      assign run[gi+1] = run[gi] + {{(CNT_W-1){1'b0}}, mask[gi]};
    end
  endgenerate

  assign count = run[BLK_N];
endmodule

// File: rtl/dbb_slot_pack.sv
module dbb_slot_pack #(
  parameter int BLK_N  = 8,
  parameter int ELEM_W = 8,
  parameter int CNT_W  = $clog2(BLK_N + 1)
) (
  input  logic [BLK_N*ELEM_W-1:0] data,
  input  logic [BLK_N-1:0]        mask,
  input  logic [BLK_N*CNT_W-1:0]  rank,
  input  logic [CNT_W-1:0]        bound,
  output logic [BLK_N*ELEM_W-1:0] vals
);
  genvar gk;
  generate
    for (gk = 0; gk < BLK_N; gk++) begin : g_slot
      localparam logic [CNT_W-1:0] SLOT_IDX = CNT_W'(gk);
      logic [ELEM_W-1:0] pick;

      always_comb begin
        pick = '0;
        for (int i = 0; i < BLK_N; i++) begin
          if (mask[i] && (rank[i*CNT_W +: CNT_W] == SLOT_IDX))
            pick = pick | data[i*ELEM_W +: ELEM_W];
        end
      end

      assign vals[gk*ELEM_W +: ELEM_W] = (SLOT_IDX < bound) ? pick : '0;
    end
  endgenerate
endmodule

// File: rtl/dbb_beat_reg.sv
module dbb_beat_reg #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PAY_W-1:0] s_pay,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PAY_W-1:0] m_pay
);
  logic             held;
  logic [PAY_W-1:0] store;

  assign s_ready = !held || m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= 1'b0;
      store <= '0;
    end else if (s_ready) begin
      held <= s_valid;
      if (s_valid) store <= s_pay;
    end
  end

  assign m_valid = held;
  assign m_pay   = store;
endmodule

// File: rtl/dbb_pack_top.sv
module dbb_pack_top
  import dbb_pkg::*;
#(
  parameter int BLK_N  = dbb_pkg::BLK_N,
  parameter int ELEM_W = dbb_pkg::ELEM_W,
  parameter int CNT_W  = $clog2(BLK_N + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BLK_N*ELEM_W-1:0] in_data,
  input  logic [CNT_W-1:0]        in_bound,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [BLK_N*ELEM_W-1:0] out_vals,
  output logic [BLK_N-1:0]        out_mask,
  output logic [CNT_W-1:0]        out_bound,
  output logic                    out_over
);
  localparam int DW    = BLK_N * ELEM_W;
  localparam int PAY_W = 1 + CNT_W + BLK_N + DW;

  logic [BLK_N-1:0]       nz_mask;
  logic [BLK_N*CNT_W-1:0] nz_rank;
  logic [CNT_W-1:0]       nz_count;
  logic [DW-1:0]          packed_vals;
  logic                   too_dense;
  logic [PAY_W-1:0]       pay_in;
  logic [PAY_W-1:0]       pay_out;

  dbb_nz_scan #(.BLK_N(BLK_N), .ELEM_W(ELEM_W), .CNT_W(CNT_W)) i_scan (
    .data  (in_data),
    .mask  (nz_mask),
    .rank  (nz_rank),
    .count (nz_count)
  );

  dbb_slot_pack #(.BLK_N(BLK_N), .ELEM_W(ELEM_W), .CNT_W(CNT_W)) i_pack (
    .data  (in_data),
    .mask  (nz_mask),
    .rank  (nz_rank),
    .bound (in_bound),
    .vals  (packed_vals)
  );

  assign too_dense = nz_count > in_bound;
  assign pay_in    = {too_dense, in_bound, nz_mask, packed_vals};

  dbb_beat_reg #(.PAY_W(PAY_W)) i_beat (
    .clk     (clk),
    .rst     (rst),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_pay   (pay_in),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_pay   (pay_out)
  );

  assign {out_over, out_bound, out_mask, out_vals} = pay_out;
endmodule

// File: rtl/dbb_pack_chk.sv
module dbb_pack_chk #(
  parameter int BLK_N  = 8,
  parameter int ELEM_W = 8,
  parameter int CNT_W  = $clog2(BLK_N + 1)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [BLK_N*ELEM_W-1:0] out_vals,
  input logic [BLK_N-1:0]        out_mask,
  input logic [CNT_W-1:0]        out_bound,
  input logic                    out_over
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_stall_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vals) && $stable(out_mask)
                                   && $stable(out_bound) && $stable(out_over)));

  p_accept_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  p_over_flag_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_over == (CNT_W'($countones(out_mask)) > out_bound)));

  genvar gk;
  generate
    for (gk = 0; gk < BLK_N; gk++) begin : g_slot_chk
      p_fill_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_over && (gk < $countones(out_mask)))
          |-> (out_vals[gk*ELEM_W +: ELEM_W] != '0));

      p_pad_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_over && (gk >= $countones(out_mask)))
          |-> (out_vals[gk*ELEM_W +: ELEM_W] == '0));

      p_above_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (gk >= int'(out_bound)))
          |-> (out_vals[gk*ELEM_W +: ELEM_W] == '0));
    end
  endgenerate
endmodule

bind dbb_pack_top dbb_pack_chk #(.BLK_N(BLK_N), .ELEM_W(ELEM_W), .CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_vals  (out_vals),
  .out_mask  (out_mask),
  .out_bound (out_bound),
  .out_over  (out_over)
);

// File: tb/test_dbb_pack_top.sv
module test_dbb_pack_top;
  localparam int BLK = 8;
  localparam int EW  = 8;
  localparam int CW  = 4;
  localparam int DW  = BLK * EW;
  localparam int NV  = 8;

  localparam logic [DW-1:0] TV_D [NV] = '{
    64'h0000_0000_0000_0000,
    64'h0807_0605_0403_0201,
    64'h0033_0000_0000_1100,
    64'h8000_0000_0000_0000,
    64'h0000_0900_0700_0005,
    64'h0A00_0000_F000_0300,
    64'hFFFE_FDFC_FBFA_F9F8,
    64'h0000_0000_FF00_00FF
  };
  localparam logic [CW-1:0] TV_B [NV] = '{
    4'd4, 4'd8, 4'd2, 4'd1, 4'd2, 4'd5, 4'd7, 4'd3
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic [CW-1:0] in_bound;
  logic          out_valid;
  logic          out_ready;
  logic [DW-1:0] out_vals;
  logic [BLK-1:0] out_mask;
  logic [CW-1:0] out_bound;
  logic          out_over;

  always #5 clk = ~clk;

  dbb_pack_top i_dbb_pack_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_bound(in_bound), .out_valid(out_valid),
    .out_ready(out_ready), .out_vals(out_vals), .out_mask(out_mask),
    .out_bound(out_bound), .out_over(out_over)
  );

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [BLK-1:0] m_mask(input logic [DW-1:0] d);
    logic [BLK-1:0] m;
    for (int i = 0; i < BLK; i++) m[i] = (d[i*EW +: EW] != 8'h00);
    return m;
  endfunction

  function automatic logic [DW-1:0] m_vals(input logic [DW-1:0] d, input int b);
    logic [DW-1:0] v;
    int k;
    v = '0;
    k = 0;
    for (int i = 0; i < BLK; i++) begin
      if (d[i*EW +: EW] != 8'h00) begin
        if (k < b) v[k*EW +: EW] = d[i*EW +: EW];
        k++;
      end
    end
    return v;
  endfunction

  task automatic cmp_out(input logic [DW-1:0] d, input logic [CW-1:0] b, input string tag);
    logic [BLK-1:0] em;
    logic           eo;
    em = m_mask(d);
    eo = ($countones(em) > int'(b));
    check(out_valid == 1'b1, {tag, " R8 valid"}, DW'(out_valid), DW'(1));
    check(out_mask == em, {tag, " R2 mask"}, DW'(out_mask), DW'(em));
    check(out_over == eo, {tag, " R5 over"}, DW'(out_over), DW'(eo));
    check(out_bound == b, {tag, " R6 bound"}, DW'(out_bound), DW'(b));
    if (!eo)
      check(out_vals == m_vals(d, int'(b)), {tag, " R3/R4 vals"}, out_vals, m_vals(d, int'(b)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] blk_a;
    logic [DW-1:0] blk_b;
    rst = 1'b1; in_valid = 1'b0; in_data = '0; in_bound = 4'd1; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R1 out_valid after reset", DW'(out_valid), DW'(0));
    check(in_ready == 1'b1, "R1 in_ready after reset", DW'(in_ready), DW'(1));

    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1; in_data = TV_D[i]; in_bound = TV_B[i];
      @(negedge clk);
      cmp_out(TV_D[i], TV_B[i], $sformatf("vec%0d", i));
      in_valid = 1'b0;
      @(negedge clk);
    end

    blk_a = 64'h0000_0042_0000_0000;
    blk_b = 64'h1100_2200_0000_3300;
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = blk_a; in_bound = 4'd3;
    @(negedge clk);
    cmp_out(blk_a, 4'd3, "stall A");
    in_data = blk_b; in_bound = 4'd6;
    check(in_ready == 1'b0, "R7 in_ready low under stall", DW'(in_ready), DW'(0));
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(out_vals == m_vals(blk_a, 3), "R7 vals held", out_vals, m_vals(blk_a, 3));
      check(out_bound == 4'd3, "R7 bound held", DW'(out_bound), DW'(3));
    end
    out_ready = 1'b1;
    @(negedge clk);
    cmp_out(blk_b, 4'd6, "R8 release B");
    in_valid = 1'b0;
    @(negedge clk);

    for (int j = 0; j < 4; j++) begin
      logic [DW-1:0] dd;
      logic [CW-1:0] bb;
      dd = TV_D[(j * 3 + 1) % NV] ^ {8{8'(j * 17)}};
      bb = CW'((j * 5) % 8 + 1);
      in_valid = 1'b1; in_data = dd; in_bound = bb;
      @(negedge clk);
      cmp_out(dd, bb, $sformatf("R9 stream%0d", j));
    end
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 drained", DW'(out_valid), DW'(0));

    in_valid = 1'b1; in_data = TV_D[1]; in_bound = 4'd8;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R1 mid-run reset", DW'(out_valid), DW'(0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule